// File: doc/BRIEF.md
# Packed Half-to-Single Float Widener

This block widens packed IEEE-754 binary16 values into binary32 values in a single registered stage. It accepts a 128-bit source word holding up to eight binary16 lanes, together with a lane-count select. In wide mode all eight lanes are converted. In narrow mode only the low four lanes are converted and the upper half of the 256-bit result is cleared. Every binary16 value has an exact binary32 form, so the datapath has no rounding. Subnormal halves come out as normalized singles. Signaling NaNs are quieted and raise an invalid indication.

The block has a denormals-are-zero control input, which it ignores. It also has an illegal-encoding input. When that input is high on an accepted request, the block produces no result. Instead it raises an undefined-operation pulse and leaves its result and invalid outputs exactly as they were. Results appear one clock after the request and are qualified by a valid strobe.

Top module: `hwiden_vec`

## Requirements
- R1: In wide mode (`wide_mode`=1), lane k converts source bits [16k+15:16k] into result bits [32k+31:32k] for k = 0..7, so lane order runs low to high.
- R2: In narrow mode (`wide_mode`=0), only lanes 0..3 (source bits 63:0) are converted, and result bits 255:128 are zero.
- R3: A normal binary16 input (exponent field 1..30) keeps its sign. Its result exponent is the input exponent plus 112. Its 10-bit fraction fills result bits 22:13, and result bits 12:0 are zero.
- R4: A subnormal binary16 input (exponent 0, fraction nonzero) yields the exactly equal normalized binary32 value. The result exponent lies between 103 and 112.
- R5: Signed zero (exponent 0, fraction 0) and signed infinity (exponent 31, fraction 0) map to the binary32 zero and infinity codes with the same sign.
- R6: A NaN input (exponent 31, fraction nonzero) keeps its sign. Its result exponent is 255, its fraction bits 8:0 appear at result bits 21:13, and result bit 22 (the quiet bit) is set.
- R7: `invalid_o` is set with a result exactly when an active lane held a signaling NaN (exponent 31, fraction bit 9 clear, fraction nonzero). Signaling NaNs in inactive lanes have no effect on it.
- R8: The `daz_en` input has no effect on the result or the flags. Subnormal inputs never raise `invalid_o`.
- R9: A request with `enc_bad`=1 produces `undef_o`=1 and `out_valid`=0 in the next cycle, and leaves `dst` and `invalid_o` unchanged.
- R10: A request with `in_valid`=1 and `enc_bad`=0 produces `out_valid`=1 with its result and flag in the next cycle.
- R11: After reset, `dst`, `invalid_o`, `out_valid` and `undef_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | 128 | Packed binary16 source lanes |
| wide_mode | input | 1 | 1 = eight lanes, 0 = four lanes with the upper result cleared |
| daz_en | input | 1 | Denormals-are-zero control; ignored |
| enc_bad | input | 1 | Illegal-encoding marker; suppresses the result |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| dst | output | 256 | Packed binary32 result lanes |
| invalid_o | output | 1 | Signaling NaN seen in an active lane |
| undef_o | output | 1 | Undefined-operation pulse for an illegal-encoding request |

## Verification
The bench builds the block with the default of eight lanes. With that setting, both the eight-lane and the four-lane modes and the upper-half clearing can be reached from the ports. Lane 0 is swept through all 65536 binary16 codes, with the mode alternating between codes. The other lanes carry scrambled codes, so in narrow mode signaling NaNs sit in inactive lanes. Directed vectors cover lane placement, `daz_en` toggling with subnormal inputs, and an illegal-encoding request that follows a flagged result.

// File: rtl/hw16_pkg.sv
`timescale 1ns/1ps
package hw16_pkg;
  localparam int H_W      = 16;
  localparam int S_W      = 32;
  localparam int H_EXP    = 5;
  localparam int H_FRAC   = 10;
  localparam int S_EXP    = 8;
  localparam int S_FRAC   = 23;
  localparam int H_BIAS   = 15;
  localparam int S_BIAS   = 127;
  localparam int BIAS_GAP = S_BIAS - H_BIAS;
  localparam int FRAC_PAD = S_FRAC - H_FRAC;
  localparam int LZ_W     = $clog2(H_FRAC + 1);

  typedef enum logic [2:0] {
    CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
  } hcls_e;

  // class of a binary16 code from its exponent and fraction fields
  function automatic hcls_e classify(logic [H_W-1:0] h);
    logic [H_EXP-1:0]  e;
    logic [H_FRAC-1:0] f;
    e = h[H_W-2 -: H_EXP];
    f = h[H_FRAC-1:0];
    if (e == '0)      return (f == '0) ? CL_ZERO : CL_SUB;
    else if (e == '1) begin
      if (f == '0)            return CL_INF;
      else if (f[H_FRAC-1])   return CL_QNAN;
      else                    return CL_SNAN;
    end
    return CL_NORM;
  endfunction

  // rebias a normal exponent
  function automatic logic [S_EXP-1:0] norm_exp(logic [H_EXP-1:0] e);
    return S_EXP'(e) + S_EXP'(BIAS_GAP);
  endfunction

  // biased exponent of a subnormal after renormalization by lz+1 places
  function automatic logic [S_EXP-1:0] sub_exp(logic [LZ_W-1:0] lz);
    return S_EXP'(BIAS_GAP) - S_EXP'(lz);
  endfunction
endpackage

// File: rtl/hw16_lzc.sv
`timescale 1ns/1ps
module hw16_lzc #(
  parameter int W  = 10,
  parameter int CW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    cnt_o = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec_i[i]) begin
        cnt_o = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hw16_lane.sv
`timescale 1ns/1ps
module hw16_lane
  import hw16_pkg::*;
(
  input  logic [H_W-1:0] h_i,
  output logic [S_W-1:0] s_o,
  output logic           snan_o,
  output logic           sub_o
);
  logic              sgn;
  logic [H_EXP-1:0]  ex;
  logic [H_FRAC-1:0] fr;
  logic [LZ_W-1:0]   lz;
  logic [H_FRAC:0]   shl;
  hcls_e             cls;

  assign {sgn, ex, fr} = h_i;

  hw16_lzc #(.W(H_FRAC), .CW(LZ_W)) u_lzc (.vec_i(fr), .cnt_o(lz));

  always_comb begin
    cls = classify(h_i);
    shl = {1'b0, fr} << (lz + LZ_W'(1));
    unique case (cls)
      CL_ZERO: s_o = {sgn, {(S_W-1){1'b0}}};
      CL_SUB:  s_o = {sgn, sub_exp(lz), shl[H_FRAC-1:0], {FRAC_PAD{1'b0}}};
      CL_NORM: s_o = {sgn, norm_exp(ex), fr, {FRAC_PAD{1'b0}}};
      CL_INF:  s_o = {sgn, {S_EXP{1'b1}}, {S_FRAC{1'b0}}};
      default: s_o = {sgn, {S_EXP{1'b1}}, 1'b1, fr[H_FRAC-2:0], {FRAC_PAD{1'b0}}};
    endcase
  end

  assign snan_o = (cls == CL_SNAN);
  assign sub_o  = (cls == CL_SUB);

  always_comb begin
    if (sub_o) begin
      // R4
      sub_norm_chk: assert (s_o[S_W-2 -: S_EXP] >= S_EXP'(BIAS_GAP - H_FRAC + 1)
                            && s_o[S_W-2 -: S_EXP] <= S_EXP'(BIAS_GAP)
                            && s_o[S_W-1] == h_i[H_W-1]);
    end
    if (snan_o) begin
      // R6
      snan_quiet_chk: assert (s_o[S_W-2 -: S_EXP] == '1 && s_o[S_FRAC-1]);
    end
  end
endmodule

// File: rtl/hwiden_vec.sv
`timescale 1ns/1ps
module hwiden_vec
  import hw16_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [LANES*16-1:0]  src,
  input  logic                 wide_mode,
  input  logic                 daz_en,
  input  logic                 enc_bad,
  output logic                 out_valid,
  output logic [LANES*32-1:0]  dst,
  output logic                 invalid_o,
  output logic                 undef_o
);
  localparam int HALF  = LANES / 2;
  localparam int DST_W = LANES * S_W;

  logic [LANES-1:0] active, snan_raw, snan_act, sub_raw;
  logic [DST_W-1:0] res_c;
  logic             accept, reject, any_snan;
  logic             daz_unused;

  // the denormals-are-zero control is deliberately not consumed
  assign daz_unused = daz_en;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [S_W-1:0] lane_s;
    hw16_lane u_lane (
      .h_i    (src[k*H_W +: H_W]),
      .s_o    (lane_s),
      .snan_o (snan_raw[k]),
      .sub_o  (sub_raw[k])
    );
    if (k < HALF) begin : g_low
      assign active[k] = 1'b1;
    end else begin : g_high
      assign active[k] = wide_mode;
    end
    assign res_c[k*S_W +: S_W] = active[k] ? lane_s : '0;
    assign snan_act[k]         = snan_raw[k] & active[k];
  end

  assign any_snan = |snan_act;
  assign accept   = in_valid & ~enc_bad;
  assign reject   = in_valid &  enc_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst       <= '0;
      invalid_o <= 1'b0;
      out_valid <= 1'b0;
      undef_o   <= 1'b0;
    end else begin
      out_valid <= accept;
      undef_o   <= reject;
      if (accept) begin
        dst       <= res_c;
        invalid_o <= any_snan;
      end
    end
  end

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wide_mode) |=> (dst[DST_W-1:DST_W/2] == '0));

  // R7
  inv_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (invalid_o == $past(|(snan_raw & active))));

  // R9
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (undef_o && !out_valid && $stable(dst) && $stable(invalid_o)));

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && !undef_o));

  // R8
  sub_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (sub_raw & active) == active) |=> !invalid_o);
endmodule

// File: tb/hwiden_vec_tb_top.sv
`timescale 1ns/1ps
module hwiden_vec_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic         wide_mode = 1'b1;
  logic         daz_en = 1'b0;
  logic         enc_bad = 1'b0;
  logic         out_valid, invalid_o, undef_o;
  logic [255:0] dst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hwiden_vec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .wide_mode(wide_mode), .daz_en(daz_en), .enc_bad(enc_bad),
    .out_valid(out_valid), .dst(dst), .invalid_o(invalid_o), .undef_o(undef_o)
  );

  typedef struct {
    bit           undef;
    bit           wide;
    logic [127:0] s;
    logic [255:0] d;
    logic         inv;
  } item_t;

  item_t       sb[$];
  logic [255:0] last_d = '0;
  logic         last_inv = 1'b0;

  // reference: renormalize by repeated shifting, independent of the RTL's count
  function automatic logic [31:0] ref_cvt(logic [15:0] h);
    logic [4:0]  e;
    logic [10:0] m;
    int          x;
    e = h[14:10];
    m = {1'b0, h[9:0]};
    if (e == 5'd0 && m == 0) return {h[15], 31'd0};
    if (e == 5'd31) begin
      if (m == 0) return {h[15], 8'hFF, 23'd0};
      return {h[15], 8'hFF, 1'b1, h[8:0], 13'd0};
    end
    if (e == 5'd0) begin
      x = 113;
      while (!m[10]) begin m = m << 1; x = x - 1; end
      return {h[15], 8'(x), m[9:0], 13'd0};
    end
    return {h[15], 8'(int'(e) - 15 + 127), h[9:0], 13'd0};
  endfunction

  function automatic bit is_snan(logic [15:0] h);
    return h[14:10] == 5'd31 && h[9:0] != 0 && !h[9];
  endfunction

  function automatic string tag_of(logic [15:0] h);
    if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R5" : "R4";
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R5" : "R6";
    return "R3";
  endfunction

  // driver: daz_en is driven freely and never enters the expectation (R8)
  task automatic drive(logic [127:0] s, bit wide, bit daz, bit bad);
    item_t it;
    @(negedge clk);
    in_valid  = 1'b1;
    src       = s;
    wide_mode = wide;
    daz_en    = daz;
    enc_bad   = bad;
    it.undef = bad;
    it.wide  = wide;
    it.s     = s;
    if (bad) begin
      it.d   = last_d;
      it.inv = last_inv;
    end else begin
      it.inv = 1'b0;
      for (int k = 0; k < 8; k++) begin
        bit act;
        act = wide || k < 4;
        it.d[32*k +: 32] = act ? ref_cvt(s[16*k +: 16]) : 32'd0;
        if (act && is_snan(s[16*k +: 16])) it.inv = 1'b1;
      end
      last_d   = it.d;
      last_inv = it.inv;
    end
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    enc_bad  = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && (out_valid || undef_o)) begin
      item_t it;
      bit bad;
      bad = 0;
      n_chk++;
      if (sb.size() == 0) begin
        $display("FAIL R10 unexpected output: actual valid=%0b undef=%0b expected none", out_valid, undef_o);
        n_fail++;
      end else begin
        it = sb.pop_front();
        if (it.undef) begin
          if (!undef_o || out_valid || dst !== it.d || invalid_o !== it.inv) begin
            $display("FAIL R9 actual undef=%0b valid=%0b inv=%0b dst=%h expected undef=1 valid=0 inv=%0b dst=%h",
                     undef_o, out_valid, invalid_o, dst, it.inv, it.d);
            bad = 1;
          end
        end else begin
          if (!out_valid || undef_o) begin
            $display("FAIL R10 actual valid=%0b undef=%0b expected valid=1 undef=0", out_valid, undef_o);
            bad = 1;
          end
          for (int k = 0; k < 8; k++) begin
            if (dst[32*k +: 32] !== it.d[32*k +: 32]) begin
              if (!it.wide && k >= 4)
                $display("FAIL R2 lane %0d actual %h expected %h", k, dst[32*k +: 32], it.d[32*k +: 32]);
              else
                $display("FAIL R1/%s lane %0d in %h actual %h expected %h", tag_of(it.s[16*k +: 16]),
                         k, it.s[16*k +: 16], dst[32*k +: 32], it.d[32*k +: 32]);
              bad = 1;
            end
          end
          if (invalid_o !== it.inv) begin
            $display("FAIL R7 actual invalid=%0b expected %0b src=%h wide=%0b", invalid_o, it.inv, it.s, it.wide);
            bad = 1;
          end
        end
        if (bad) n_fail++;
      end
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      $display("FAIL watchdog expired: actual running expected finished");
      n_fail++;
      n_chk++;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    n_chk++;
    if (dst !== '0 || out_valid !== 1'b0 || invalid_o !== 1'b0 || undef_o !== 1'b0) begin
      $display("FAIL R11 actual dst=%h valid=%0b inv=%0b undef=%0b expected all zero",
               dst, out_valid, invalid_o, undef_o);
      n_fail++;
    end

    // R1 placement with distinct normal values per lane
    drive(128'h4800_4700_4600_4500_4400_4200_4000_3C00, 1, 0, 0);
    // R2 narrow with ones in the upper source half
    drive(128'hFFFF_7C00_3C00_C000_0001_8000_7BFF_0400, 0, 0, 0);
    // R7 signaling NaN only in an inactive lane
    drive(128'h7C01_0000_0000_0000_3C00_3C00_3C00_3C00, 0, 0, 0);
    // R7 the same vector in wide mode raises invalid
    drive(128'h7C01_0000_0000_0000_3C00_3C00_3C00_3C00, 1, 0, 0);
    // R9 illegal encoding after a flagged result holds dst and flag
    drive(128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444, 1, 0, 1);
    // R6 quiet and signaling NaN payloads, both signs
    drive(128'hFE00_7E00_FD55_7D55_FC01_7C01_FFFF_7FFF, 1, 0, 0);
    // R8 subnormals with daz on and off must match
    drive(128'h83FF_0200_8001_0001_03FF_0155_0010_0001, 1, 1, 0);
    drive(128'h83FF_0200_8001_0001_03FF_0155_0010_0001, 1, 0, 0);
    // R9 again in narrow mode, back to back with a good request
    drive(128'h0, 0, 1, 1);
    drive(128'h0000_0000_0000_0000_8000_0000_FC00_7C00, 0, 0, 0);
    idle();

    // R3 R4 R5 R6: exhaustive sweep of lane 0
    for (int c = 0; c < 65536; c++) begin
      logic [127:0] s;
      s[15:0] = 16'(c);
      for (int k = 1; k < 8; k++) s[16*k +: 16] = 16'(c) ^ 16'(k * 16'h2F1B);
      drive(s, c[0], c[1], 0);
    end
    idle();
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 actual %0d results missing expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule